// File: doc/BRIEF.md
# Cipher Engine Access-Violation Status Register

This block holds the read-only status word of a block-cipher accelerator and watches the accelerator's register bus for accesses that are illegal at the moment they happen. Each cycle it sees the bus address with its read and write strobes. It also sees the engine's busy flag, its completion pulse, the configured start mode, the last-output-data setting, the start and software-reset control strobes, and the security flags from the write-protection logic. From these it keeps a data-ready bit, a sticky violation-detected bit, a two-bit code naming the most recent violation, and a security-event bit.

Illegal accesses are also reported combinationally in the cycle they occur, through a hit flag and a kind code. A companion qualifier tells the mode register whether a write may be accepted. A mode write that is classified as a violation is not accepted.

Start mode is encoded as 0 for manual, 1 for auto and 2 for start-on-input-write. Register addresses are parameters. The control register, the key registers and the input data registers form the write-only set.

Top module: `cse_status`

## Requirements
- R1: After reset, status_word reads zero except bit 16, which follows the security flags.
- R2: status_word places data-ready at bit 0, violation-detected at bit 8, violation kind at bits 13:12 and security event at bit 16. Every other bit reads zero.
- R3: The violation kinds are as follows. Kind 0 is an input-data write while busy with start mode 2. Kind 1 is an output-data read while busy. Kind 2 is a mode-register write while busy. Kind 3 is a read of a write-only address. viol_hit and viol_kind report the violation combinationally in the same cycle.
- R4: The kind field holds the code of the latest violation and replaces any earlier code.
- R5: Violation-detected is sticky. It stays set until a software-reset strobe, which also zeroes the kind field.
- R6: Data-ready sets on a completion pulse. It clears on a start strobe, on a software reset, or on a read of any output data address.
- R7: With last-output-data enabled and start mode 0 or 1, a write to any input data address clears data-ready. In start mode 2, or with the setting off, such a write leaves data-ready unchanged.
- R8: Bit 16 is high in the same cycle whenever any security flag is high, and low otherwise.
- R9: A software reset wins over a completion pulse and over any violation in the same cycle. A completion pulse wins over a data-ready clear in the same cycle.
- R10: Reading the status address has no side effect. mode_wr_ok is high only for a mode-register write that is not a violation.
- R11: When several violations occur in one cycle, the lowest kind code is recorded and reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Register bus byte address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| busy | input | 1 | Engine is processing |
| done_pulse | input | 1 | Encryption or decryption completed |
| start_mode | input | 2 | 0 manual, 1 auto, 2 start on input write |
| lod_en | input | 1 | Last-output-data setting |
| ctl_start | input | 1 | Start strobe from the control register |
| ctl_swrst | input | 1 | Software-reset strobe from the control register |
| sec_flags | input | SEC_W | Security flags from write-protection status |
| status_word | output | 32 | Read-only status word |
| viol_hit | output | 1 | Illegal access in this cycle |
| viol_kind | output | 2 | Kind code of this cycle's violation |
| mode_wr_ok | output | 1 | Mode-register write may be accepted |

## Verification
viol_hit, viol_kind, mode_wr_ok and status bit 16 are combinational. Bits 0, 8 and 13:12 are taken from one register stage, so they show a stimulus after the first rising edge that samples it. The bench drives each vector on a falling edge. It checks the combinational outputs one time step later, before the rising edge. It then checks the registered bits just after that rising edge, while the inputs are still held. Asynchronous reset is checked one time step after rst_n falls.

// File: rtl/cse_pkg.sv
package cse_pkg;

    localparam int STAT_W   = 32;
    localparam int DRDY_BIT = 0;
    localparam int DET_BIT  = 8;
    localparam int KIND_LSB = 12;
    localparam int SEC_BIT  = 16;

    typedef enum logic [1:0] {
        VK_IDATA_BUSY = 2'd0,
        VK_ODATA_BUSY = 2'd1,
        VK_MODE_BUSY  = 2'd2,
        VK_WO_READ    = 2'd3
    } viol_kind_e;

    typedef enum logic [1:0] {
        SM_MANUAL = 2'd0,
        SM_AUTO   = 2'd1,
        SM_IDATA  = 2'd2
    } start_mode_e;

    typedef struct packed {
        logic ctrl;
        logic mode;
        logic key;
        logic idata;
        logic odata;
    } addr_hits_t;

    typedef struct packed {
        logic       drdy;
        logic       det;
        viol_kind_e kind;
    } stat_state_t;

endpackage

// File: rtl/cse_addr_dec.sv
module cse_addr_dec
    import cse_pkg::*;
#(
    parameter int AW         = 8,
    parameter int CTRL_ADDR  = 'h00,
    parameter int MODE_ADDR  = 'h04,
    parameter int KEY_BASE   = 'h20,
    parameter int KEY_CNT    = 4,
    parameter int IDATA_BASE = 'h40,
    parameter int IDATA_CNT  = 2,
    parameter int ODATA_BASE = 'h50,
    parameter int ODATA_CNT  = 2
) (
    input  logic [AW-1:0] bus_addr,
    output addr_hits_t    hits,
    output logic          wo_hit
);

    localparam int WSTEP = 4;

    logic [KEY_CNT-1:0]   key_m;
    logic [IDATA_CNT-1:0] idata_m;
    logic [ODATA_CNT-1:0] odata_m;

    for (genvar i = 0; i < KEY_CNT; i++) begin : g_key
        assign key_m[i] = (bus_addr == AW'(KEY_BASE + WSTEP * i));
    end
    for (genvar i = 0; i < IDATA_CNT; i++) begin : g_idata
        assign idata_m[i] = (bus_addr == AW'(IDATA_BASE + WSTEP * i));
    end
    for (genvar i = 0; i < ODATA_CNT; i++) begin : g_odata
        assign odata_m[i] = (bus_addr == AW'(ODATA_BASE + WSTEP * i));
    end

    always_comb begin
        hits.ctrl  = (bus_addr == AW'(CTRL_ADDR));
        hits.mode  = (bus_addr == AW'(MODE_ADDR));
        hits.key   = |key_m;
        hits.idata = |idata_m;
        hits.odata = |odata_m;
        wo_hit     = hits.ctrl | hits.key | hits.idata;
    end

endmodule

// File: rtl/cse_viol_class.sv
module cse_viol_class
    import cse_pkg::*;
(
    input  addr_hits_t  hits,
    input  logic        wo_hit,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic        busy,
    input  logic [1:0]  start_mode,
    output logic        viol_hit,
    output viol_kind_e  viol_kind,
    output logic        mode_wr_ok
);

    logic [3:0] cond;

    always_comb begin
        cond[0] = bus_wr & hits.idata & busy & (start_mode == SM_IDATA);
        cond[1] = bus_rd & hits.odata & busy;
        cond[2] = bus_wr & hits.mode & busy;
        cond[3] = bus_rd & wo_hit;

        viol_hit = |cond;
        // lowest code wins when several conditions meet
        if (cond[0])      viol_kind = VK_IDATA_BUSY;
        else if (cond[1]) viol_kind = VK_ODATA_BUSY;
        else if (cond[2]) viol_kind = VK_MODE_BUSY;
        else              viol_kind = VK_WO_READ;

        mode_wr_ok = bus_wr & hits.mode & ~cond[2];
    end

endmodule

// File: rtl/cse_state.sv
module cse_state
    import cse_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        done,
    input  logic        start,
    input  logic        swrst,
    input  logic        rd_clr,
    input  logic        wr_clr,
    input  logic        viol_hit,
    input  viol_kind_e  viol_kind,
    output stat_state_t st_q
);

    stat_state_t st_d;

    always_comb begin
        st_d = st_q;
        if (swrst) begin
            st_d = '0;
        end else begin
            if (done)                             st_d.drdy = 1'b1;
            else if (start | rd_clr | wr_clr)     st_d.drdy = 1'b0;
            if (viol_hit) begin
                st_d.det  = 1'b1;
                st_d.kind = viol_kind;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/cse_status.sv
module cse_status
    import cse_pkg::*;
#(
    parameter int AW         = 8,
    parameter int SEC_W      = 4,
    parameter int CTRL_ADDR  = 'h00,
    parameter int MODE_ADDR  = 'h04,
    parameter int KEY_BASE   = 'h20,
    parameter int KEY_CNT    = 4,
    parameter int IDATA_BASE = 'h40,
    parameter int IDATA_CNT  = 2,
    parameter int ODATA_BASE = 'h50,
    parameter int ODATA_CNT  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic             busy,
    input  logic             done_pulse,
    input  logic [1:0]       start_mode,
    input  logic             lod_en,
    input  logic             ctl_start,
    input  logic             ctl_swrst,
    input  logic [SEC_W-1:0] sec_flags,
    output logic [31:0]      status_word,
    output logic             viol_hit,
    output logic [1:0]       viol_kind,
    output logic             mode_wr_ok
);

    addr_hits_t  hits;
    logic        wo_hit;
    viol_kind_e  kind_w;
    stat_state_t st_q;
    logic        rd_clr;
    logic        wr_clr;

    cse_addr_dec #(
        .AW(AW), .CTRL_ADDR(CTRL_ADDR), .MODE_ADDR(MODE_ADDR),
        .KEY_BASE(KEY_BASE), .KEY_CNT(KEY_CNT),
        .IDATA_BASE(IDATA_BASE), .IDATA_CNT(IDATA_CNT),
        .ODATA_BASE(ODATA_BASE), .ODATA_CNT(ODATA_CNT)
    ) u_dec (
        .bus_addr (bus_addr),
        .hits     (hits),
        .wo_hit   (wo_hit)
    );

    cse_viol_class u_cls (
        .hits       (hits),
        .wo_hit     (wo_hit),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .busy       (busy),
        .start_mode (start_mode),
        .viol_hit   (viol_hit),
        .viol_kind  (kind_w),
        .mode_wr_ok (mode_wr_ok)
    );

    always_comb begin
        rd_clr = bus_rd & hits.odata;
        wr_clr = bus_wr & hits.idata & lod_en &
                 ((start_mode == SM_MANUAL) | (start_mode == SM_AUTO));
    end

    cse_state u_st (
        .clk       (clk),
        .rst_n     (rst_n),
        .done      (done_pulse),
        .start     (ctl_start),
        .swrst     (ctl_swrst),
        .rd_clr    (rd_clr),
        .wr_clr    (wr_clr),
        .viol_hit  (viol_hit),
        .viol_kind (kind_w),
        .st_q      (st_q)
    );

    always_comb begin
        viol_kind                          = kind_w;
        status_word                        = '0;
        status_word[DRDY_BIT]              = st_q.drdy;
        status_word[DET_BIT]               = st_q.det;
        status_word[KIND_LSB+1:KIND_LSB]   = st_q.kind;
        status_word[SEC_BIT]               = |sec_flags;
    end

endmodule

// File: rtl/cse_status_chk.sv
module cse_status_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] stat_lo,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic        busy,
    input logic        done_pulse,
    input logic        ctl_start,
    input logic        ctl_swrst,
    input logic        viol_hit,
    input logic [1:0]  viol_kind,
    input logic        mode_wr_ok
);

    // R5 and R9: software reset empties every registered field
    p_swrst_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_swrst |=> (stat_lo == 16'h0));

    // R6: completion sets data-ready unless a software reset is present
    p_done_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse && !ctl_swrst |=> stat_lo[0]);

    // R3 and R4: a violation is recorded with its kind
    p_viol_record_r3: assert property (@(posedge clk) disable iff (!rst_n)
        viol_hit && !ctl_swrst |=> stat_lo[8] && (stat_lo[13:12] == $past(viol_kind)));

    // R5: the detected flag stays set
    p_det_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stat_lo[8] && !ctl_swrst |=> stat_lo[8]);

    // R10: accepted mode writes never happen while busy
    p_mode_discard_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr_ok |-> !busy);

    // R10: without any strobe the registered fields hold
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd && !bus_wr && !done_pulse && !ctl_start && !ctl_swrst |=> $stable(stat_lo));

endmodule

bind cse_status cse_status_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stat_lo    (status_word[15:0]),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .busy       (busy),
    .done_pulse (done_pulse),
    .ctl_start  (ctl_start),
    .ctl_swrst  (ctl_swrst),
    .viol_hit   (viol_hit),
    .viol_kind  (viol_kind),
    .mode_wr_ok (mode_wr_ok)
);

// File: tb/cse_status_tb.sv
`timescale 1ns/1ps
module cse_status_tb;

    localparam int HALF = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 0, bus_rd = 0, busy = 0, done_pulse = 0;
    logic [1:0]  start_mode = '0;
    logic        lod_en = 0, ctl_start = 0, ctl_swrst = 0;
    logic [3:0]  sec_flags = '0;
    logic [31:0] status_word;
    logic        viol_hit, mode_wr_ok;
    logic [1:0]  viol_kind;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #HALF clk = ~clk;

    cse_status u_dut (.*);

    typedef struct packed {
        logic [7:0]  addr;
        logic        wr, rd, busy, done;
        logic [1:0]  sm;
        logic        lod, st, sw;
        logic [3:0]  sec;
        logic [31:0] exp_st;
        logic        hit;
        logic [1:0]  kind;
        logic        mok;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 22;
    // addr wr rd busy done sm lod st sw sec | status hit kind mok req
    localparam vec_t VEC [NV] = '{
        '{8'h00,0,0,0,0,2'd0,0,0,0,4'h0, 32'h0000_0000,0,2'd0,0,4'd2},  // R2 idle
        '{8'h00,0,0,0,1,2'd0,0,0,0,4'h0, 32'h0000_0001,0,2'd0,0,4'd6},  // R6 done sets
        '{8'h1C,0,1,0,0,2'd0,0,0,0,4'h0, 32'h0000_0001,0,2'd0,0,4'd10}, // R10 status read quiet
        '{8'h54,0,1,0,0,2'd0,0,0,0,4'h0, 32'h0000_0000,0,2'd0,0,4'd6},  // R6 odata read clears
        '{8'h00,0,0,0,1,2'd0,0,0,0,4'h0, 32'h0000_0001,0,2'd0,0,4'd6},
        '{8'h00,0,0,0,0,2'd0,0,1,0,4'h0, 32'h0000_0000,0,2'd0,0,4'd6},  // R6 start clears
        '{8'h00,0,0,0,1,2'd0,0,1,0,4'h0, 32'h0000_0001,0,2'd0,0,4'd9},  // R9 done beats start
        '{8'h40,1,0,0,0,2'd0,1,0,0,4'h0, 32'h0000_0000,0,2'd0,0,4'd7},  // R7 lod manual clears
        '{8'h00,0,0,0,1,2'd0,0,0,0,4'h0, 32'h0000_0001,0,2'd0,0,4'd6},
        '{8'h44,1,0,0,0,2'd2,1,0,0,4'h0, 32'h0000_0001,0,2'd0,0,4'd7},  // R7 mode 2 keeps
        '{8'h40,1,0,0,0,2'd1,0,0,0,4'h0, 32'h0000_0001,0,2'd0,0,4'd7},  // R7 lod off keeps
        '{8'h40,1,0,1,0,2'd2,0,0,0,4'h0, 32'h0000_0101,1,2'd0,0,4'd3},  // R3 kind 0
        '{8'h50,0,1,1,0,2'd0,0,0,0,4'h0, 32'h0000_1100,1,2'd1,0,4'd3},  // R3 kind 1
        '{8'h04,1,0,1,0,2'd0,0,0,0,4'h0, 32'h0000_2100,1,2'd2,0,4'd10}, // R10 mode write discarded
        '{8'h24,0,1,0,0,2'd0,0,0,0,4'h0, 32'h0000_3100,1,2'd3,0,4'd4},  // R4 latest kind 3
        '{8'h04,1,0,0,0,2'd0,0,0,0,4'h0, 32'h0000_3100,0,2'd0,1,4'd5},  // R5 sticky, R10 ok
        '{8'h00,0,0,0,0,2'd0,0,0,0,4'h4, 32'h0001_3100,0,2'd0,0,4'd8},  // R8 security bit
        '{8'h00,0,1,0,1,2'd0,0,0,1,4'h0, 32'h0000_0000,1,2'd3,0,4'd9},  // R9 swrst beats all
        '{8'h40,1,1,1,0,2'd2,0,0,0,4'h0, 32'h0000_0100,1,2'd0,0,4'd11}, // R11 lowest code
        '{8'h00,0,0,0,0,2'd0,0,0,1,4'h0, 32'h0000_0000,0,2'd0,0,4'd5},  // R5 swrst clears
        '{8'h40,1,0,1,0,2'd0,0,0,0,4'h0, 32'h0000_0000,0,2'd0,0,4'd3},  // R3 mode 0 no viol
        '{8'h1C,0,1,1,0,2'd0,0,0,0,4'h0, 32'h0000_0000,0,2'd0,0,4'd10}  // R10 status read busy
    };

    task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        bus_addr = '0; bus_wr = 0; bus_rd = 0; busy = 0; done_pulse = 0;
        start_mode = '0; lod_en = 0; ctl_start = 0; ctl_swrst = 0; sec_flags = '0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(2 * HALF * 200000);
        errors++;
        $display("FAIL R1 watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        idle_inputs();
        repeat (2) @(negedge clk);
        chk(1, status_word, 32'h0, "status in reset");        // R1
        rst_n = 1'b1;
        @(negedge clk);
        chk(1, status_word, 32'h0, "status after reset");     // R1

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            bus_addr = VEC[i].addr; bus_wr = VEC[i].wr; bus_rd = VEC[i].rd;
            busy = VEC[i].busy; done_pulse = VEC[i].done; start_mode = VEC[i].sm;
            lod_en = VEC[i].lod; ctl_start = VEC[i].st; ctl_swrst = VEC[i].sw;
            sec_flags = VEC[i].sec;
            #1;
            chk(VEC[i].req, {31'b0, viol_hit}, {31'b0, VEC[i].hit}, "viol_hit");
            if (VEC[i].hit)
                chk(VEC[i].req, {30'b0, viol_kind}, {30'b0, VEC[i].kind}, "viol_kind");
            chk(VEC[i].req, {31'b0, mode_wr_ok}, {31'b0, VEC[i].mok}, "mode_wr_ok");
            @(posedge clk);
            #1;
            chk(VEC[i].req, status_word, VEC[i].exp_st, "status_word");
        end

        // R6 and R3: build up state again, then R1 asynchronous reset clears it
        @(negedge clk); idle_inputs(); done_pulse = 1;
        @(negedge clk); idle_inputs(); bus_addr = 8'h00; bus_rd = 1;
        @(negedge clk); idle_inputs();
        chk(3, status_word, 32'h0000_3101, "state before reset");
        rst_n = 1'b0;
        #1;
        chk(1, status_word, 32'h0, "asynchronous reset");
        // R8: security bit follows the flags even in reset, and drops with them
        sec_flags = 4'h1;
        #1;
        chk(8, status_word, 32'h0001_0000, "security bit set");
        sec_flags = 4'h0;
        #1;
        chk(8, status_word, 32'h0, "security bit clear");
        finish_run();
    end

endmodule